// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block is a synchronous front end for an external asynchronous static RAM of 32768 bytes. A user issues one read or one write at a time through a request/ready handshake. The controller then drives the address bus and the active-low chip-select, output-enable and write-enable strobes, and holds each phase for the number of clock cycles needed to meet the memory's minimum times. On a read it returns the captured byte with a one-cycle valid pulse.

Every phase length is a ceiling of a nanosecond limit divided by the clock-period parameter, and is never less than one cycle. The controller controls the direction of the shared 8-bit data bus. It exposes the bus as a pad triple: output data, output enable and input data. It turns its own drivers on only after the memory has had time to release the bus following a read.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is active and right after it is released, CS, OE and WE are high, the data drivers are off, ready_o is high and rvalid_o is low.
- R2: Strobe encoding: idle is CS high; a read is CS low, OE low, WE high; a write is CS low and WE low with OE kept high.
- R3: A read holds CS and OE low for exactly RD_CYC cycles, where RD_CYC is the largest of ceil(70/P), ceil(70/P) and ceil(35/P) with a floor of 1, and P = CLK_NS. This is 9 cycles at P = 8 ns.
- R4: Read data is sampled at the clock edge that ends the last read cycle. At that edge CS and OE rise, ready_o rises, and rvalid_o is high for exactly one cycle with the byte on rdata_o.
- R5: A write holds WE low for exactly WP_CYC cycles. WP_CYC is the largest of ceil(50/P), ceil(60/P), ceil(60/P), ceil(30/P) and ceil(70/P)-2, with a floor of 1, which gives 8 at P = 8 ns. The drivers are on with constant data throughout WE low and for one further cycle in which CS stays low. CS stays low for at least ceil(70/P) cycles.
- R6: The data drivers are never on while OE is low. They are turned on only after OE has been high for TA_CYC = ceil(30/P) cycles (4 at P = 8 ns), so they never overlap the memory's output release time.
- R7: The address and CS do not change while CS is low.
- R8: ready_o is low while an access is in progress. A request presented while ready_o is low has no effect: it starts no access and changes no memory content.
- R9: A read of any address from 0 to 0x7FFF returns the byte last written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Word address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Controller idle, able to accept a request |
| rdata_o | output | 8 | Captured read data |
| rvalid_o | output | 1 | One-cycle pulse, rdata_o valid |
| mem_addr_o | output | 15 | Memory address bus |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Data to the bus pad |
| mem_dq_oe_o | output | 1 | Pad driver enable |
| mem_dq_i | input | 8 | Data from the bus pad |

## Verification
The bench uses a cycle model of the memory that returns a garbage byte until the 70 ns access time has passed. The model also keeps driving for 30 ns after OE rises. A capture one edge early, or a driver turned on during the release window, therefore shows up as a wrong byte or a bus collision.

The directed cases cover these patterns:
- write then immediate read of the same address, which checks the data path;
- read then immediate write, which tests the turnaround at its tightest spacing;
- the lowest and highest addresses with 0x00 and 0xFF data;
- a read of a never-written address, which must return the model's default byte;
- a request held while the controller is busy, which must start no access and leave memory unchanged.

A seeded random mix of reads and writes over a small address pool follows, so that reads often hit freshly written bytes.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_WAIT,
    ST_WR_PULSE,
    ST_WR_END
  } ctrl_state_e;

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_TIMER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (done_o == ($past(load_val_i) == '0)));  // R3

endmodule

// File: rtl/sram_turnaround.sv
`timescale 1ns/1ps
module sram_turnaround #(
  parameter int unsigned TA_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_n_i,
  output logic drv_ok_o
);
  localparam int unsigned CW = $clog2(TA_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(TA_CYC);
  localparam logic [CW-1:0] THR = CW'(TA_CYC - 1);

  // full cycles OE has been high, saturating
  logic [CW-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hi_cnt_q <= SAT;
    else if (!oe_n_i)         hi_cnt_q <= '0;
    else if (hi_cnt_q != SAT) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  // sampled at an edge: cycles completed so far = hi_cnt_q + 1
  assign drv_ok_o = oe_n_i && (hi_cnt_q >= THR);

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_NS = 8,
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned T_RC   = 70,
  parameter int unsigned T_AA   = 70,
  parameter int unsigned T_OE   = 35,
  parameter int unsigned T_HZ   = 30,
  parameter int unsigned T_OHZ  = 30,
  parameter int unsigned T_WP   = 50,
  parameter int unsigned T_CW   = 60,
  parameter int unsigned T_AW   = 60,
  parameter int unsigned T_DW   = 30,
  parameter int unsigned T_WC   = 70
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned RD_CYC = umax(umax(ns2cyc(T_RC, CLK_NS), ns2cyc(T_AA, CLK_NS)),
                                        ns2cyc(T_OE, CLK_NS));
  localparam int unsigned WC_CYC = ns2cyc(T_WC, CLK_NS);
  localparam int unsigned WC_REM = (WC_CYC > 2) ? WC_CYC - 2 : 1;
  localparam int unsigned WP_CYC = umax(umax(umax(ns2cyc(T_WP, CLK_NS), ns2cyc(T_CW, CLK_NS)),
                                             umax(ns2cyc(T_AW, CLK_NS), ns2cyc(T_DW, CLK_NS))),
                                        WC_REM);
  localparam int unsigned TA_CYC = umax(ns2cyc(T_HZ, CLK_NS), ns2cyc(T_OHZ, CLK_NS));
  localparam int unsigned CNT_W  = $clog2(umax(RD_CYC, WP_CYC) + 1);

  ctrl_state_e       state_q;
  logic              cs_n_q, oe_n_q, we_n_q, dq_oe_q, rvalid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              drv_ok, phase_done, tmr_load;
  logic [CNT_W-1:0]  tmr_val;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(RD_CYC - 1);
    if (state_q == ST_IDLE && req_i && !we_i) begin
      tmr_load = 1'b1;
    end else if (state_q == ST_WR_WAIT && drv_ok) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(WP_CYC - 1);
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (phase_done)
  );

  sram_turnaround #(.TA_CYC(TA_CYC)) u_ta (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .oe_n_i   (oe_n_q),
    .drv_ok_o (drv_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cs_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      dq_oe_q  <= 1'b0;
      rvalid_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          cs_n_q  <= 1'b0;
          if (we_i) begin
            state_q <= ST_WR_WAIT;
          end else begin
            oe_n_q  <= 1'b0;
            state_q <= ST_RD;
          end
        end
        ST_RD: if (phase_done) begin
          rdata_q  <= mem_dq_i;
          rvalid_q <= 1'b1;
          cs_n_q   <= 1'b1;
          oe_n_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        ST_WR_WAIT: if (drv_ok) begin
          dq_oe_q <= 1'b1;
          we_n_q  <= 1'b0;
          state_q <= ST_WR_PULSE;
        end
        ST_WR_PULSE: if (phase_done) begin
          we_n_q  <= 1'b1;
          state_q <= ST_WR_END;
        end
        ST_WR_END: begin
          cs_n_q  <= 1'b1;
          dq_oe_q <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign rdata_o     = rdata_q;
  assign rvalid_o    = rvalid_q;
  assign mem_addr_o  = addr_q;
  assign mem_cs_no   = cs_n_q;
  assign mem_oe_no   = oe_n_q;
  assign mem_we_no   = we_n_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = dq_oe_q;

  AST_WE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_cs_no);  // R2
  AST_WE_KEEPS_OE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_oe_no);  // R2
  AST_WE_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_dq_oe_o);  // R5
  AST_DRV_NEEDS_OE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);  // R6
  AST_DRV_RISE_AFTER_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> $past(mem_oe_no));  // R6
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && $past(!mem_cs_no)) |-> $stable(mem_addr_o));  // R7
  AST_RVALID_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ready_o);  // R4
  AST_RVALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);  // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs_no |-> !ready_o);  // R8

endmodule

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
  localparam int CLK = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready_o, rvalid_o;
  logic [7:0]  rdata_o;
  logic [14:0] mem_addr;
  logic        cs_n, oe_n, we_n, dq_oe;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i = 8'hEE;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  sram_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .mem_addr_o(mem_addr), .mem_cs_no(cs_n), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  function automatic int cyc(int ns);
    int c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_EXP = 9;  // max(ceil 70, ceil 70, ceil 35) at 8 ns
  int wp_exp, ta_exp, wc_exp, rd_exp;

  function automatic logic [7:0] dflt(int a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  logic [7:0] mdl [int];
  logic [7:0] ref_mem [int];

  function automatic logic [7:0] mdl_get(int a);
    return mdl.exists(a) ? mdl[a] : dflt(a);
  endfunction
  function automatic logic [7:0] ref_get(int a);
    return ref_mem.exists(a) ? ref_mem[a] : dflt(a);
  endfunction

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  // memory model and bus monitor, one sample per cycle after the edge
  int cs_run, oe_run, we_run, hold, rd_n, n_access, n_write;
  bit p_cs, p_oe, p_we, p_dq_oe, p_rd, addr_ok, we_drv_ok, is_wr, rv_drop;
  logic [14:0] cs_addr, p_addr;
  logic [7:0]  p_dq, we_dat;

  always @(posedge clk) begin
    bit rd_act, mdl_drv;
    #1;
    if (!rst_n) begin
      p_cs = 1; p_oe = 1; p_we = 1; p_dq_oe = 0; p_rd = 0; hold = 0; rd_n = 0;
      rv_drop = 0; dq_i = 8'hEE;
    end else begin
      rd_act  = !cs_n && !oe_n && we_n;
      mdl_drv = rd_act || hold > 0;
      if (dq_oe && !p_dq_oe) chk(!mdl_drv, "R6 driver on during memory release", 1, 0);
      else if (dq_oe && mdl_drv) chk(0, "R6 bus collision", 1, 0);
      hold = rd_act ? ta_exp : (hold > 0 ? hold - 1 : 0);
      if (rv_drop) begin chk(!rvalid_o, "R4 rvalid width", rvalid_o, 0); rv_drop = 0; end
      if (!cs_n && p_cs) begin
        n_access++; cs_addr = mem_addr; addr_ok = 1; cs_run = 0; oe_run = 0; is_wr = 0;
      end
      if (!cs_n) begin
        cs_run++;
        if (mem_addr != cs_addr) addr_ok = 0;
        if (!oe_n) oe_run++;
      end
      if (!we_n && p_we) begin
        chk(oe_n && !cs_n, "R2 write encoding", {cs_n, oe_n}, 2'b01);
        we_run = 0; we_drv_ok = 1; is_wr = 1; we_dat = dq_o;
      end
      if (!we_n) begin
        we_run++;
        if (!dq_oe || dq_o != we_dat) we_drv_ok = 0;
      end
      if (we_n && !p_we) begin
        chk(we_run == wp_exp, "R5 WE low cycles", we_run, wp_exp);
        chk(we_drv_ok && dq_oe && !cs_n, "R5 data drive window", {we_drv_ok, dq_oe, cs_n}, 3'b110);
        mdl[int'(p_addr)] = p_dq;
        n_write++;
      end
      if (cs_n && !p_cs) begin
        chk(addr_ok, "R7 address held", addr_ok, 1);
        if (is_wr) chk(cs_run >= wc_exp, "R5 write cycle length", cs_run, wc_exp);
        else begin
          chk(cs_run == rd_exp && oe_run == rd_exp, "R3 read window", cs_run, rd_exp);
          chk(rvalid_o && ready_o, "R4 valid with ready", {rvalid_o, ready_o}, 2'b11);
          rv_drop = 1;
        end
      end
      if (rd_act) rd_n = p_rd ? rd_n + 1 : 0;
      dq_i = (rd_act && (rd_n + 1) * CLK >= 70) ? mdl_get(int'(mem_addr)) : 8'hEE;
      p_cs = cs_n; p_oe = oe_n; p_we = we_n; p_dq_oe = dq_oe; p_rd = rd_act;
      p_addr = mem_addr; p_dq = dq_o;
    end
  end

  task automatic access(bit w, logic [14:0] a, logic [7:0] d);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0; addr = 15'($urandom); wdata = 8'($urandom); we = 1'($urandom);
    chk(!ready_o, "R8 busy after accept", ready_o, 0);
    if (w) begin
      ref_mem[int'(a)] = d;
      while (!ready_o) @(negedge clk);
    end else begin
      while (!rvalid_o) @(negedge clk);
      chk(rdata_o == ref_get(int'(a)), "R9 read data", rdata_o, ref_get(int'(a)));
    end
  endtask

  task automatic poke_while_busy(logic [14:0] a);
    int acc0, wr0;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    acc0 = n_access; wr0 = n_write;
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = ~ref_get(int'(a));
    repeat (3) begin
      @(negedge clk);
      chk(!ready_o, "R8 ready low while busy", ready_o, 0);
    end
    req = 0;
    while (!rvalid_o) @(negedge clk);
    chk(rdata_o == ref_get(int'(a)), "R9 read data", rdata_o, ref_get(int'(a)));
    repeat (6) @(negedge clk);
    chk(n_access == acc0 + 1, "R8 no extra access", n_access, acc0 + 1);
    chk(n_write == wr0, "R8 no extra write", n_write, wr0);
    access(0, a, 8'h00);
  endtask

  initial begin
    logic [14:0] pool [16];
    wp_exp = mx(mx(mx(cyc(50), cyc(60)), mx(cyc(60), cyc(30))), mx(cyc(70) - 2, 1));
    ta_exp = mx(cyc(30), cyc(30));
    wc_exp = cyc(70);
    rd_exp = mx(mx(cyc(70), cyc(70)), cyc(35));
    chk(rd_exp == RD_EXP, "R3 expected window", rd_exp, RD_EXP);
    void'($urandom(32'd20240611));
    repeat (3) begin
      @(negedge clk);
      chk(cs_n && oe_n && we_n && !dq_oe && !rvalid_o, "R1 reset outputs",
          {cs_n, oe_n, we_n, dq_oe, rvalid_o}, 5'b11100);
    end
    rst_n = 1;
    @(negedge clk);
    chk(ready_o && cs_n && oe_n && we_n && !dq_oe && !rvalid_o, "R1 after reset",
        {ready_o, cs_n, oe_n, we_n, dq_oe, rvalid_o}, 6'b111100);
    repeat (2) @(negedge clk);
    chk(cs_n, "R2 idle deselected", cs_n, 1);

    access(1, 15'h0000, 8'h00);
    access(0, 15'h0000, 8'h00);
    access(1, 15'h7FFF, 8'hFF);
    access(0, 15'h7FFF, 8'h00);
    access(0, 15'h1234, 8'h00);      // unwritten: default byte
    access(1, 15'h1234, 8'hA5);      // write right after read: turnaround R6
    access(0, 15'h1234, 8'h00);
    access(1, 15'h0001, 8'h3C);
    access(1, 15'h0002, 8'hC3);
    access(0, 15'h0001, 8'h00);
    access(0, 15'h0002, 8'h00);
    poke_while_busy(15'h0001);

    foreach (pool[i]) pool[i] = 15'($urandom);
    for (int n = 0; n < 120; n++) begin
      access(1'($urandom), pool[$urandom % 16], 8'($urandom));
    end

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule